// File: doc/BRIEF.md
# Bit and byte permutation unit

This execution unit handles a family of 32-bit data rearrangement operations that take register operands and produce one result. A single operand feeds five of them: leading-zero count, full bit reversal, reversal of the four bytes of a word, a byte swap inside each 16-bit half, and a byte swap of the low half followed by sign extension. A sixth operation builds the result byte by byte. It takes each byte from one of two operands, and a per-lane flag bit from an external flag source makes the choice.

Along with each request the unit receives the register indices the instruction named. It checks them for encodings that have no defined meaning. Index 15, the program counter, must not appear as destination or source. The single-operand forms carry their source index twice, and the two copies must match. A request that breaks either rule is not computed. It comes back with the unpredictable flag raised and a zero result. Every request is answered exactly one clock later.

Top module: `bperm_unit`

## Requirements
- R1: `out_valid` is high in the cycle after each clock edge at which `in_valid` was high and `rst_n` high. It is low after any edge at which `in_valid` was low or `rst_n` was low (synchronous, active-low reset). `out_unpred` is never high while `out_valid` is low.
- R2: Opcode 0 (count leading zeros) returns the number of zero bits above the highest set bit of `in_rm_val`. The result is 32 for an all-zero operand and 0 when bit 31 is set.
- R3: Opcode 1 (bit reverse) returns a word in which bit i of `in_rm_val` appears at bit 31-i.
- R4: Opcode 2 (word byte reverse) moves byte 0 of `in_rm_val` to byte 3, byte 1 to byte 2, byte 2 to byte 1 and byte 3 to byte 0.
- R5: Opcode 3 (halfword byte swap) returns ((x >> 8) & 0x00FF00FF) | ((x << 8) & 0xFF00FF00) for x = `in_rm_val`.
- R6: Opcode 4 (signed low-half swap) exchanges bits [7:0] and [15:8] of `in_rm_val`. It then fills bits [31:16] with the new bit 15.
- R7: Opcode 5 (flag-steered select) builds result byte k (k = 0..3, byte k = bits [8k+7:8k]) from `in_rn_val` when `in_ge[k]` is 1 and from `in_rm_val` when it is 0.
- R8: For opcodes 0 to 4, `in_rn_idx` different from `in_rm_idx` makes the request unpredictable. Opcode 5 does not require the two indices to match.
- R9: A request whose `in_rd_idx`, `in_rn_idx` or `in_rm_idx` equals 15 is unpredictable, whatever the opcode.
- R10: Opcodes 6 and 7 are reserved and always unpredictable. An unpredictable request returns `out_unpred` = 1 and `out_result` = 0. A predictable one returns `out_unpred` = 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Request strobe |
| in_op | input | 3 | Opcode (0..5 defined, 6..7 reserved) |
| in_rd_idx | input | 4 | Destination register index |
| in_rn_idx | input | 4 | First source register index |
| in_rm_idx | input | 4 | Second source register index |
| in_rn_val | input | 32 | First source operand |
| in_rm_val | input | 32 | Second source operand |
| in_ge | input | 4 | Per-byte select flags |
| out_valid | output | 1 | Result strobe, one cycle after the request |
| out_result | output | 32 | Result word |
| out_unpred | output | 1 | Request encoding was unpredictable |

## Verification
The bench builds the unit with its defaults: a 32-bit data path and 4-bit register indices. At that index width every triple of destination and source indices can be swept in full for all eight opcodes. The sweep reaches every combination of program-counter use and source mismatch. Every bit position of the leading-zero count is visited, and all sixteen flag patterns drive the byte select. Pseudo-random words exercise the permutations against bench-side arithmetic, and a reset is applied while requests are in flight.

// File: rtl/bperm_pkg.sv
// Package: bperm_pkg
// Opcode encoding and helpers shared by the permutation unit.
// Assumes a 3-bit opcode field. Encodings 6 and 7 are reserved.
package bperm_pkg;

    typedef enum logic [2:0] {
        OP_CLZ   = 3'd0,
        OP_RBIT  = 3'd1,
        OP_REV   = 3'd2,
        OP_REV16 = 3'd3,
        OP_REVSH = 3'd4,
        OP_SEL   = 3'd5,
        OP_RSV6  = 3'd6,
        OP_RSV7  = 3'd7
    } bperm_op_e;

    // True for operations that read one source named by both index fields
    function automatic logic op_single_src(input bperm_op_e op);
        return (op == OP_CLZ) || (op == OP_RBIT) || (op == OP_REV) ||
               (op == OP_REV16) || (op == OP_REVSH);
    endfunction

    // True for encodings that name a defined operation
    function automatic logic op_defined(input bperm_op_e op);
        return op_single_src(op) || (op == OP_SEL);
    endfunction

endpackage

// File: rtl/bperm_legality.sv
// Module: bperm_legality
// Flags encodings with no defined meaning: a reserved opcode, the program
// counter index in any register field, or differing duplicate source
// fields on a single-operand form.
// Assumes the program counter has index PC_IDX.
module bperm_legality
    import bperm_pkg::*;
#(
    parameter int IDX_W  = 4,
    parameter int PC_IDX = 15
) (
    input  bperm_op_e        op,
    input  logic [IDX_W-1:0] rd_idx,
    input  logic [IDX_W-1:0] rn_idx,
    input  logic [IDX_W-1:0] rm_idx,
    output logic             illegal
);

    localparam logic [IDX_W-1:0] PC_CODE = IDX_W'(PC_IDX);

    logic uses_pc;
    logic src_mismatch;
    logic reserved;

    // Detect the program counter in any register field
    always_comb begin
        uses_pc = (rd_idx == PC_CODE) || (rn_idx == PC_CODE) || (rm_idx == PC_CODE);
    end

    // Duplicate source fields must agree on single-operand forms
    always_comb begin
        src_mismatch = op_single_src(op) && (rn_idx != rm_idx);
    end

    // Reserved opcodes and final combination
    always_comb begin
        reserved = !op_defined(op);
        illegal  = reserved || uses_pc || src_mismatch;
    end

endmodule

// File: rtl/bperm_clz.sv
// Module: bperm_clz
// Counts the zero bits above the most significant set bit of a word.
// Returns DATA_W for an all-zero word. Purely combinational.
module bperm_clz #(
    parameter int DATA_W = 32
) (
    input  logic [DATA_W-1:0] val,
    output logic [DATA_W-1:0] count
);

    localparam int CNT_W = $clog2(DATA_W + 1);

    logic [CNT_W-1:0] cnt;

    // Scan upward so that the highest set bit decides the count last
    always_comb begin
        cnt = CNT_W'(DATA_W);
        for (int i = 0; i < DATA_W; i++) begin
            if (val[i]) begin
                cnt = CNT_W'(DATA_W - 1 - i);
            end
        end
    end

    // Zero-extend the count to the data width
    always_comb begin
        count = {{(DATA_W - CNT_W){1'b0}}, cnt};
    end

endmodule

// File: rtl/bperm_permute.sv
// Module: bperm_permute
// Bit and byte rearrangements of the second operand, plus the
// flag-steered byte select between both operands.
// Assumes DATA_W is a multiple of 16. Purely combinational.
module bperm_permute
    import bperm_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  bperm_op_e                op,
    input  logic [DATA_W-1:0]        rn_val,
    input  logic [DATA_W-1:0]        rm_val,
    input  logic [DATA_W/8-1:0]      ge,
    output logic [DATA_W-1:0]        result
);

    localparam int LANES  = DATA_W / 8;
    localparam int HALVES = DATA_W / 16;
    localparam int NIBS   = DATA_W / 4;

    logic [DATA_W-1:0] byte_rev;
    logic [DATA_W-1:0] nib_swap;
    logic [DATA_W-1:0] bit_rev;
    logic [DATA_W-1:0] half_swap;
    logic [DATA_W-1:0] low_swap_sx;
    logic [DATA_W-1:0] lane_sel;
    logic [15:0]       low_swap;

    // Byte reversal of the word, and the flag-steered byte select
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign byte_rev[8*g +: 8] = rm_val[8*(LANES-1-g) +: 8];
        assign nib_swap[8*g +: 8] = {byte_rev[8*g +: 4], byte_rev[8*g+4 +: 4]};
        assign lane_sel[8*g +: 8] = ge[g] ? rn_val[8*g +: 8] : rm_val[8*g +: 8];
    end

    // Bit reversal finished by mirroring the four bits inside each nibble
    for (genvar q = 0; q < NIBS; q++) begin : g_nib
        for (genvar b = 0; b < 4; b++) begin : g_bit
            assign bit_rev[4*q + b] = nib_swap[4*q + 3 - b];
        end
    end

    // Byte swap inside each 16-bit half
    for (genvar h = 0; h < HALVES; h++) begin : g_half
        assign half_swap[16*h +: 16] = {rm_val[16*h +: 8], rm_val[16*h+8 +: 8]};
    end

    // Low-half swap with sign extension from the new bit 15
    always_comb begin
        low_swap    = {rm_val[7:0], rm_val[15:8]};
        low_swap_sx = {{(DATA_W-16){low_swap[15]}}, low_swap};
    end

    // Pick the variant named by the opcode
    always_comb begin
        unique case (op)
            OP_RBIT:  result = bit_rev;
            OP_REV:   result = byte_rev;
            OP_REV16: result = half_swap;
            OP_REVSH: result = low_swap_sx;
            OP_SEL:   result = lane_sel;
            default:  result = '0;
        endcase
    end

endmodule

// File: rtl/bperm_unit.sv
// Module: bperm_unit
// Top of the permutation unit: checks legality, computes every operation
// in parallel and registers the chosen result one clock after the request.
// Assumes a synchronous active-low reset and the program counter at the
// highest register index.
module bperm_unit
    import bperm_pkg::*;
#(
    parameter int DATA_W    = 32,
    parameter int REG_IDX_W = 4
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   in_valid,
    input  logic [2:0]             in_op,
    input  logic [REG_IDX_W-1:0]   in_rd_idx,
    input  logic [REG_IDX_W-1:0]   in_rn_idx,
    input  logic [REG_IDX_W-1:0]   in_rm_idx,
    input  logic [DATA_W-1:0]      in_rn_val,
    input  logic [DATA_W-1:0]      in_rm_val,
    input  logic [DATA_W/8-1:0]    in_ge,
    output logic                   out_valid,
    output logic [DATA_W-1:0]      out_result,
    output logic                   out_unpred
);

    localparam int PC_IDX = (1 << REG_IDX_W) - 1;
    localparam logic [REG_IDX_W-1:0] PC_CODE = REG_IDX_W'(PC_IDX);

    bperm_op_e         op;
    logic              illegal;
    logic [DATA_W-1:0] clz_res;
    logic [DATA_W-1:0] perm_res;
    logic [DATA_W-1:0] next_res;

    // Interpret the opcode field
    always_comb begin
        op = bperm_op_e'(in_op);
    end

    bperm_legality #(
        .IDX_W  (REG_IDX_W),
        .PC_IDX (PC_IDX)
    ) u_legality (
        .op      (op),
        .rd_idx  (in_rd_idx),
        .rn_idx  (in_rn_idx),
        .rm_idx  (in_rm_idx),
        .illegal (illegal)
    );

    bperm_clz #(
        .DATA_W (DATA_W)
    ) u_clz (
        .val   (in_rm_val),
        .count (clz_res)
    );

    bperm_permute #(
        .DATA_W (DATA_W)
    ) u_permute (
        .op     (op),
        .rn_val (in_rn_val),
        .rm_val (in_rm_val),
        .ge     (in_ge),
        .result (perm_res)
    );

    // Merge the count path, and force zero on illegal requests
    always_comb begin
        if (illegal) begin
            next_res = '0;
        end else if (op == OP_CLZ) begin
            next_res = clz_res;
        end else begin
            next_res = perm_res;
        end
    end

    // Output register, which holds the last result while idle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid  <= 1'b0;
            out_unpred <= 1'b0;
            out_result <= '0;
        end else begin
            out_valid  <= in_valid;
            out_unpred <= in_valid && illegal;
            if (in_valid) begin
                out_result <= next_res;
            end
        end
    end

    assert_valid_latency_R1: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    assert_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid && !out_unpred);

    assert_clz_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && op == OP_CLZ && in_rm_val == '0 && in_rn_idx == in_rm_idx &&
        in_rm_idx != PC_CODE && in_rd_idx != PC_CODE
        |=> out_result == DATA_W && !out_unpred);

    assert_src_mismatch_R8: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && op_single_src(op) && in_rn_idx != in_rm_idx |=> out_unpred);

    assert_sel_no_match_R8: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && op == OP_SEL && in_rd_idx != PC_CODE && in_rn_idx != PC_CODE &&
        in_rm_idx != PC_CODE |=> !out_unpred);

    assert_pc_unpred_R9: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && (in_rd_idx == PC_CODE || in_rn_idx == PC_CODE || in_rm_idx == PC_CODE)
        |=> out_unpred);

    assert_unpred_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
        out_unpred |-> out_result == '0 && out_valid);

endmodule

// File: tb/bperm_unit_bench.sv
`timescale 1ns/1ps
module bperm_unit_bench;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        in_valid;
    logic [2:0]  in_op;
    logic [3:0]  in_rd_idx, in_rn_idx, in_rm_idx;
    logic [31:0] in_rn_val, in_rm_val;
    logic [3:0]  in_ge;
    logic        out_valid;
    logic [31:0] out_result;
    logic        out_unpred;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;
    logic [31:0] seed = 32'h1234_5678;

    always #2.5 clk = ~clk;

    bperm_unit u_bperm_unit (
        .clk        (clk),
        .rst_n      (rst_n),
        .in_valid   (in_valid),
        .in_op      (in_op),
        .in_rd_idx  (in_rd_idx),
        .in_rn_idx  (in_rn_idx),
        .in_rm_idx  (in_rm_idx),
        .in_rn_val  (in_rn_val),
        .in_rm_val  (in_rm_val),
        .in_ge      (in_ge),
        .out_valid  (out_valid),
        .out_result (out_result),
        .out_unpred (out_unpred)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] rnd();
        seed = seed ^ (seed << 13);
        seed = seed ^ (seed >> 17);
        seed = seed ^ (seed << 5);
        return seed;
    endfunction

    function automatic logic [31:0] m_clz(input logic [31:0] v);
        int n = 0;
        bit seen = 1'b0;
        for (int i = 31; i >= 0; i--) begin
            if (v[i]) seen = 1'b1;
            if (!seen) n++;
        end
        return 32'(n);
    endfunction

    function automatic logic [31:0] m_result(input int op, input logic [31:0] vn,
                                             input logic [31:0] vm, input logic [3:0] ge);
        logic [31:0] r = '0;
        logic [15:0] t;
        case (op)
            0: r = m_clz(vm);
            1: for (int i = 0; i < 32; i++) r[31-i] = vm[i];
            2: r = {vm[7:0], vm[15:8], vm[23:16], vm[31:24]};
            3: r = ((vm >> 8) & 32'h00FF_00FF) | ((vm << 8) & 32'hFF00_FF00);
            4: begin t = {vm[7:0], vm[15:8]}; r = {{16{t[15]}}, t}; end
            5: for (int k = 0; k < 4; k++) r[8*k +: 8] = ge[k] ? vn[8*k +: 8] : vm[8*k +: 8];
            default: r = '0;
        endcase
        return r;
    endfunction

    // One request, checked at the negedge after the capturing edge
    task automatic run(input int op, input int rd, input int rn, input int rm,
                       input logic [31:0] vn, input logic [31:0] vm, input logic [3:0] ge);
        bit pc, mism, rsv, unp;
        string tag, ltag;
        logic [31:0] exp;
        in_valid = 1'b1; in_op = 3'(op);
        in_rd_idx = 4'(rd); in_rn_idx = 4'(rn); in_rm_idx = 4'(rm);
        in_rn_val = vn; in_rm_val = vm; in_ge = ge;
        @(negedge clk);
        in_valid = 1'b0;
        pc   = (rd == 15) || (rn == 15) || (rm == 15);
        mism = (op <= 4) && (rn != rm);
        rsv  = (op >= 6);
        unp  = pc || mism || rsv;
        case (op)
            0: tag = "R2"; 1: tag = "R3"; 2: tag = "R4";
            3: tag = "R5"; 4: tag = "R6"; 5: tag = "R7";
            default: tag = "R10";
        endcase
        ltag = rsv ? "R10" : pc ? "R9" : mism ? "R8" : "R10";
        exp = unp ? 32'h0 : m_result(op, vn, vm, ge);
        check("R1 valid", {31'b0, out_valid}, 32'h1);
        check(ltag, {31'b0, out_unpred}, {31'b0, unp});
        check(unp ? "R10 zero result" : tag, out_result, exp);
    endtask

    initial begin
        rst_n = 1'b0; in_valid = 1'b1; in_op = 3'd0;
        in_rd_idx = 4'd1; in_rn_idx = 4'd2; in_rm_idx = 4'd2;
        in_rn_val = '0; in_rm_val = '0; in_ge = '0;
        repeat (3) @(negedge clk);
        check("R1 reset valid", {31'b0, out_valid}, 32'h0);
        check("R1 reset unpred", {31'b0, out_unpred}, 32'h0);
        rst_n = 1'b1; in_valid = 1'b0;
        @(negedge clk);
        check("R1 idle", {31'b0, out_valid}, 32'h0);

        // Edge values for the count and the permutations
        run(0, 1, 3, 3, 32'h0, 32'h0, 4'h0);
        run(0, 1, 3, 3, 32'h0, 32'h8000_0000, 4'h0);
        run(0, 1, 3, 3, 32'h0, 32'hFFFF_FFFF, 4'h0);
        for (int k = 0; k < 32; k++) begin
            logic [31:0] v = (32'h1 << k) | (rnd() & ((32'h1 << k) - 32'h1));
            run(0, 4, 6, 6, 32'h0, v, 4'h0);
        end
        run(4, 2, 5, 5, 32'h0, 32'h1234_0080, 4'h0);
        run(4, 2, 5, 5, 32'h0, 32'hFFFF_7F00, 4'h0);
        run(1, 2, 5, 5, 32'h0, 32'h0000_0001, 4'h0);
        run(2, 2, 5, 5, 32'h0, 32'h1122_3344, 4'h0);
        run(3, 2, 5, 5, 32'h0, 32'h1122_3344, 4'h0);

        // Pseudo-random operands for every defined operation
        for (int op = 0; op < 6; op++) begin
            for (int n = 0; n < 200; n++) begin
                if (op == 5) run(op, 0, 1, 2, rnd(), rnd(), 4'(n));
                else         run(op, 0, 7, 7, rnd(), rnd(), 4'h0);
            end
        end

        // All flag patterns for the select
        for (int g = 0; g < 16; g++) run(5, 3, 4, 9, 32'hAABB_CCDD, 32'h1122_3344, 4'(g));

        // Full sweep of register index triples for every opcode
        for (int op = 0; op < 8; op++)
            for (int rd = 0; rd < 16; rd++)
                for (int rn = 0; rn < 16; rn++)
                    for (int rm = 0; rm < 16; rm++)
                        run(op, rd, rn, rm, rnd(), rnd(), 4'(rn));

        // Gap after a request leaves both strobes low
        run(2, 1, 2, 2, 32'h0, 32'hDEAD_BEEF, 4'h0);
        @(negedge clk);
        check("R1 gap valid", {31'b0, out_valid}, 32'h0);
        check("R1 gap unpred", {31'b0, out_unpred}, 32'h0);

        // Reset applied while a request is presented
        in_valid = 1'b1; in_op = 3'd6; rst_n = 1'b0;
        @(negedge clk);
        check("R1 reset in flight valid", {31'b0, out_valid}, 32'h0);
        check("R1 reset in flight unpred", {31'b0, out_unpred}, 32'h0);
        rst_n = 1'b1; in_valid = 1'b0;
        @(negedge clk);

        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            fails++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

endmodule